// File: doc/BRIEF.md
# DRAM Cycle Decoder with Parallel Test Mode

This block is the device-side control of a small dynamic memory model. It watches the row strobe, column strobe, write-enable and output-enable pins (all active low) and samples them on a system clock. On every falling edge of the row strobe it decides which kind of cycle starts and reports that as a two-bit code. A mode register records whether the part is in a parallel test mode.

Normal operation is the usual one. A write stores the data word into the single location picked by the full column address. A read returns that one location. In test mode the column address is split into a group index and a two-bit lane index, and the lane index is not used. A write copies each data bit into all four lanes of its group. A read returns, per I/O bit, a pass flag: 1 when the four stored bits agree and 0 when they do not.

Test mode is entered by a cycle that has both write-enable and column strobe low before the row strobe falls. It is left by an ordinary refresh, either a column-before-row refresh or a row-only refresh. Ordinary row cycles and repeated set cycles keep the part in test mode. The pins follow strobe levels, so there is no valid/ready handshake.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset the cycle code is 0 (idle), test mode is off, `lane_we` is all zeros and `dout_en` is low.
- R2: At each row-strobe fall the cycle code is loaded one clock later and then held until the next fall. Column strobe high gives code 1 (row cycle). Column strobe low with write-enable high gives code 2 (refresh). Both low give code 3 (test-mode set).
- R3: A row-strobe fall that gives code 3 turns test mode on.
- R4: Test mode turns off in two cases. A row-strobe fall that gives code 2 turns it off. So does the rise that ends a code-1 cycle in which the column strobe never fell (a row-only refresh).
- R5: While in test mode, two kinds of cycle leave test mode on: a code-1 cycle that includes a column access, and a further code-3 cycle.
- R6: In normal mode, a column-strobe fall inside a code-1 cycle with write-enable low stores `din` in the one location selected by the full `col_addr`. One clock later `lane_we` pulses for one cycle with only bit `col_addr[1:0]` set.
- R7: In normal mode, a column-strobe fall inside a code-1 cycle with write-enable high loads `dout` one clock later with the word at the full `col_addr`.
- R8: In test mode, a write stores each `din` bit into all four lanes of the group `col_addr[COL_W-1:2]`. `lane_we` pulses all ones.
- R9: In test mode, a read drives `dout[i]` to 1 when the four lanes of the group hold equal values in bit i, and to 0 otherwise.
- R10: In test mode, `col_addr[1:0]` has no effect on reads or writes.
- R11: `dout_en` is high only while a read result is held and `oe_n` is low. The result is dropped on a write access, or when the row and column strobes are both sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| col_addr | input | COL_W | Column address |
| din | input | IO_W | Write data |
| cyc_type | output | 2 | Cycle code of the latest row-strobe fall |
| test_mode | output | 1 | Parallel test mode active |
| lane_we | output | 4 | Per-lane write pulse |
| dout | output | IO_W | Read data or per-bit pass flags |
| dout_en | output | 1 | Output drive enable |

## Verification
The bench uses the defaults: COL_W = 4, IO_W = 4, and two lane bits. That gives four groups of four lanes, so a test write can be checked against its untouched neighbour groups. With these sizes, one group can be made to disagree in every bit by writing a single location of it in normal mode. The bench then checks that a test-mode read of that group fails in every bit, while a uniform group still passes. Four I/O bits with mixed data show that each pass flag covers its own bit only.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_ROW  = 2'd1,
    CYC_RFSH = 2'd2,
    CYC_TSET = 2'd3
  } cyc_t;
endpackage

// File: rtl/dcd_cycle_ctl.sv
module dcd_cycle_ctl
  import dcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cyc_t cyc_q,
  output logic tmode_q,
  output logic acc_go,
  output logic acc_wr
);
  logic ras_q, cas_q, cas_seen;
  logic ras_fall, ras_rise;
  cyc_t cyc_next;

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;

  always_comb begin
    if (cas_n)     cyc_next = CYC_ROW;
    else if (we_n) cyc_next = CYC_RFSH;
    else           cyc_next = CYC_TSET;
  end

  // column access: column strobe falls while a row cycle is already open
  assign acc_go = ~ras_q & ~ras_n & cas_q & ~cas_n & (cyc_q == CYC_ROW);
  assign acc_wr = acc_go & ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      cas_seen <= 1'b0;
      cyc_q    <= CYC_IDLE;
      tmode_q  <= 1'b0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall)    cas_seen <= 1'b0;
      else if (acc_go) cas_seen <= 1'b1;
      if (ras_fall) begin
        cyc_q <= cyc_next;
        if (cyc_next == CYC_TSET)      tmode_q <= 1'b1;
        else if (cyc_next == CYC_RFSH) tmode_q <= 1'b0;
      end else if (ras_rise && cyc_q == CYC_ROW && !cas_seen) begin
        tmode_q <= 1'b0;
      end
    end
  end

  a_r2_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cyc_q) |-> $past(ras_fall));
  a_r3_set_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && !we_n) |=> tmode_q);
  a_r4_refresh_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && we_n) |=> !tmode_q);
endmodule

// File: rtl/dcd_cell_array.sv
module dcd_cell_array #(
  parameter int IO_W      = 4,
  parameter int COL_W     = 4,
  parameter int LANE_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_go,
  input  logic                 acc_wr,
  input  logic                 tmode,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic [COL_W-1:0]     col,
  input  logic [IO_W-1:0]      din,
  output logic [(1<<LANE_BITS)-1:0] lane_we,
  output logic [IO_W-1:0]      dout,
  output logic                 rd_valid
);
  localparam int CELLS = 1 << COL_W;
  localparam int LANES = 1 << LANE_BITS;
  localparam int GRP_W = COL_W - LANE_BITS;

  logic [IO_W-1:0] mem [CELLS];
  logic [GRP_W-1:0] grp;
  logic [LANE_BITS-1:0] lane;
  logic [IO_W-1:0] grp_word [LANES];
  logic [IO_W-1:0] cmp_flags;

  assign grp  = col[COL_W-1:LANE_BITS];
  assign lane = col[LANE_BITS-1:0];

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    assign grp_word[gl] = mem[{grp, LANE_BITS'(gl)}];
  end

  for (genvar gi = 0; gi < IO_W; gi++) begin : g_cmp
    always_comb begin
      cmp_flags[gi] = 1'b1;
      for (int l = 1; l < LANES; l++)
        if (grp_word[l][gi] != grp_word[0][gi]) cmp_flags[gi] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < CELLS; c++) mem[c] <= '0;
      lane_we  <= '0;
      dout     <= '0;
      rd_valid <= 1'b0;
    end else begin
      lane_we <= '0;
      if (acc_wr) begin
        if (tmode) begin
          for (int l = 0; l < LANES; l++) mem[{grp, LANE_BITS'(l)}] <= din;
          lane_we <= '1;
        end else begin
          mem[col] <= din;
          lane_we  <= LANES'(1) << lane;
        end
        rd_valid <= 1'b0;
      end else if (acc_go) begin
        dout     <= tmode ? cmp_flags : mem[col];
        rd_valid <= 1'b1;
      end else if (ras_n && cas_n) begin
        rd_valid <= 1'b0;
      end
    end
  end

  a_r6_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !tmode) |=> ($countones(lane_we) == 1));
  a_r8_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && tmode) |=> (lane_we == '1));
  a_r11_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_n && !acc_go) |=> !rd_valid);
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int IO_W  = 4,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [COL_W-1:0] col_addr,
  input  logic [IO_W-1:0]  din,
  output logic [1:0]       cyc_type,
  output logic             test_mode,
  output logic [3:0]       lane_we,
  output logic [IO_W-1:0]  dout,
  output logic             dout_en
);
  localparam int LANE_BITS = 2;

  cyc_t cyc_w;
  logic acc_go, acc_wr, rd_valid;

  dcd_cycle_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cyc_q(cyc_w), .tmode_q(test_mode), .acc_go(acc_go), .acc_wr(acc_wr)
  );

  dcd_cell_array #(.IO_W(IO_W), .COL_W(COL_W), .LANE_BITS(LANE_BITS)) u_arr (
    .clk(clk), .rst_n(rst_n), .acc_go(acc_go), .acc_wr(acc_wr),
    .tmode(test_mode), .ras_n(ras_n), .cas_n(cas_n), .col(col_addr),
    .din(din), .lane_we(lane_we), .dout(dout), .rd_valid(rd_valid)
  );

  assign cyc_type = cyc_w;
  assign dout_en  = rd_valid & ~oe_n;
endmodule

// File: tb/sim_dram_cycle_decoder.sv
module sim_dram_cycle_decoder;
  logic clk = 1'b0;
  logic rst_n, ras_n, cas_n, we_n, oe_n;
  logic [3:0] col_addr, din;
  logic [1:0] cyc_type;
  logic test_mode, dout_en;
  logic [3:0] lane_we, dout;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_cycle_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .col_addr(col_addr), .din(din), .cyc_type(cyc_type),
    .test_mode(test_mode), .lane_we(lane_we), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ras_fall(input logic c, input logic w);
    cas_n = c; we_n = w; step();
    ras_n = 1'b0; step();
  endtask

  task automatic ras_rise();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; step();
  endtask

  // column access: outputs are registered at the edge inside step()
  task automatic col_acc(input logic [3:0] c, input logic wr, input logic [3:0] d, input logic oe);
    col_addr = c; din = d; we_n = ~wr; oe_n = oe; cas_n = 1'b0; step();
  endtask

  task automatic cas_up();
    cas_n = 1'b1; we_n = 1'b1; step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1; col_addr = 0; din = 0;
    step(); step(); rst_n = 1'b1; step();
    chk("R1 cyc_type", 8'(cyc_type), 8'd0);
    chk("R1 test_mode", 8'(test_mode), 8'd0);
    chk("R1 lane_we", 8'(lane_we), 8'd0);
    chk("R1 dout_en", 8'(dout_en), 8'd0);
  endtask

  task automatic t_normal();
    ras_fall(1'b1, 1'b1);
    chk("R2 row code", 8'(cyc_type), 8'd1);
    col_acc(4'd5, 1'b1, 4'hA, 1'b1);
    chk("R6 lane one-hot col5", 8'(lane_we), 8'h02);
    cas_up();
    chk("R6 lane pulse ends", 8'(lane_we), 8'h00);
    col_acc(4'd6, 1'b1, 4'h3, 1'b1);
    chk("R6 lane one-hot col6", 8'(lane_we), 8'h04);
    cas_up();
    col_acc(4'd5, 1'b0, 4'h0, 1'b0);
    chk("R7 read col5", 8'(dout), 8'h0A);
    chk("R11 en with oe low", 8'(dout_en), 8'd1);
    cas_up();
    chk("R11 held while ras low", 8'(dout_en), 8'd1);
    col_acc(4'd6, 1'b0, 4'h0, 1'b1);
    chk("R7 read col6", 8'(dout), 8'h03);
    chk("R11 off with oe high", 8'(dout_en), 8'd0);
    cas_up();
    oe_n = 1'b0;
    ras_rise();
    chk("R11 dropped after strobes high", 8'(dout_en), 8'd0);
    chk("R2 code held after rise", 8'(cyc_type), 8'd1);
    oe_n = 1'b1;
  endtask

  task automatic t_refresh_code();
    ras_fall(1'b0, 1'b1);
    chk("R2 refresh code", 8'(cyc_type), 8'd2);
    chk("R4 refresh keeps normal", 8'(test_mode), 8'd0);
    ras_rise();
  endtask

  task automatic t_enter();
    ras_fall(1'b0, 1'b0);
    chk("R2 set code", 8'(cyc_type), 8'd3);
    chk("R3 test mode on", 8'(test_mode), 8'd1);
    ras_rise();
  endtask

  task automatic t_test_rw();
    ras_fall(1'b1, 1'b1);
    col_acc(4'd8, 1'b1, 4'hA, 1'b1);
    chk("R8 all lanes", 8'(lane_we), 8'h0F);
    cas_up();
    col_acc(4'd9, 1'b0, 4'h0, 1'b0);
    chk("R9 uniform group passes", 8'(dout), 8'h0F);
    cas_up();
    col_acc(4'd1, 1'b0, 4'h0, 1'b0);
    chk("R9 untouched group passes", 8'(dout), 8'h0F);
    cas_up();
    ras_rise();
    chk("R5 access cycle keeps mode", 8'(test_mode), 8'd1);
    ras_fall(1'b0, 1'b0);
    ras_rise();
    chk("R5 repeat set keeps mode", 8'(test_mode), 8'd1);
  endtask

  task automatic t_exit_and_mix();
    ras_fall(1'b0, 1'b1);
    chk("R4 refresh exits", 8'(test_mode), 8'd0);
    ras_rise();
    ras_fall(1'b1, 1'b1);
    col_acc(4'd11, 1'b0, 4'h0, 1'b1);
    chk("R8 copy in lane 3", 8'(dout), 8'h0A);
    cas_up();
    col_acc(4'd10, 1'b1, 4'h5, 1'b1);
    cas_up();
    col_acc(4'd8, 1'b0, 4'h0, 1'b1);
    chk("R7 neighbour intact", 8'(dout), 8'h0A);
    cas_up();
    ras_rise();
    t_enter();
    ras_fall(1'b1, 1'b1);
    col_acc(4'd9, 1'b0, 4'h0, 1'b0);
    chk("R9 mixed group fails", 8'(dout), 8'h00);
    cas_up();
    col_acc(4'd13, 1'b1, 4'h6, 1'b1);
    cas_up();
    col_acc(4'd15, 1'b0, 4'h0, 1'b0);
    chk("R10 lane bits ignored on read", 8'(dout), 8'h0F);
    cas_up();
    ras_rise();
  endtask

  task automatic t_ras_only_exit();
    ras_fall(1'b1, 1'b1);
    chk("R4 mode kept during ras-only", 8'(test_mode), 8'd1);
    ras_rise();
    chk("R4 ras-only exits", 8'(test_mode), 8'd0);
    ras_fall(1'b1, 1'b1);
    col_acc(4'd12, 1'b0, 4'h0, 1'b1);
    chk("R10 test write filled lane 0", 8'(dout), 8'h06);
    cas_up();
    ras_rise();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_normal();
    t_refresh_code();
    t_enter();
    t_test_rw();
    t_exit_and_mix();
    t_ras_only_exit();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule